// File: doc/BRIEF.md
# Priority Interrupt Controller Registers

This block collects 64 level-sensitive interrupt request inputs and reduces them to a single request towards a CPU. Each request carries a level and an event code. Software reaches it through a small word-wide register port. Each source has an enable bit and a 4-bit priority field. A global control bit selects the pin-decoding mode used elsewhere in the system. Enables and the control bit are changed through paired write-one-to-set and write-one-to-clear addresses, so no read-modify-write sequence is needed.

The sources form two 32-bit banks: sources 0 to 31 are the low bank and sources 32 to 63 the high bank. The arbiter is purely combinational, so the request output follows source and mask-level inputs in the same cycle. Register writes take effect at the clock edge that samples them. Event codes come from a per-source table. By default the code of source i is `EVT_BASE + EVT_STEP*i`, and any entry can be replaced by a non-zero value in `EVT_OVR`, so that a non-linear map can be fixed at build time.

Top module: `prio_intc`

## Requirements
- R1: A write to 0x70 (low bank) or 0x78 (high bank) sets the enable of every source whose data bit is 1. Sources whose data bit is 0 keep their enable. Reading 0x70/0x78 returns the enable bits, with bit n of the word standing for source n (low bank) or source n+32 (high bank).
- R2: A write to 0x80 (low bank) or 0x88 (high bank) clears the enable of every source whose data bit is 1. Sources whose data bit is 0 keep their enable.
- R3: The control bit sits at bit 0. A write with data bit 0 set to address 0x00 sets it, and a write with data bit 0 set to 0x08 clears it. Writes whose bit 0 is 0 leave it unchanged. Both addresses read it back at bit 0, and it drives `mode_o`.
- R4: There are eight priority registers at 0x10 + 8*k for k = 0..7. Source i uses bits [4*(i%8)+3 : 4*(i%8)] of register i/8. Each register is written and read as a whole word.
- R5: Reads of 0x50/0x58 return the raw source inputs of the low/high bank. Reads of 0x60/0x68 return the pending status of the low/high bank, which is the raw input ANDed with the enables.
- R6: A source competes only while its input is high, its enable is 1 and its priority is nonzero. The request is level-sensitive and drops as soon as the input drops.
- R7: Among competing sources the largest priority wins. When priorities are equal, the lowest source index wins.
- R8: `irq_o` is high only when the winning priority is strictly greater than `cpu_lvl_i`. While it is high, `irq_lvl_o` carries that priority and `irq_code_o` carries the winner's event code (default 0x200 + 0x20*i). While it is low, both are 0.
- R9: After reset all enables are 0, all priority fields are 0 and the control bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| src_i | input | 64 | Level-sensitive source requests |
| cpu_lvl_i | input | 4 | CPU interrupt mask level |
| mode_o | output | 1 | Control bit |
| irq_o | output | 1 | Interrupt request to CPU |
| irq_lvl_o | output | 4 | Priority of the granted request |
| irq_code_o | output | 12 | Event code of the granted request |

## Verification
A register write lands at the rising edge that samples `wr_en_i`. Its effect on read data and on the request outputs is therefore due one edge later. The bench drives the write at a falling edge and samples one full cycle afterwards. Source and mask-level changes pass through combinational logic only, so the bench applies them at a falling edge and samples a nanosecond later, within the same cycle and before the next rising edge. Read data is combinational in the address and is checked the same way.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int          PRI_W    = 4,
  parameter int          CODE_W   = 12,
  parameter int          ADDR_W   = 8,
  parameter logic [11:0] EVT_BASE = 12'h200,
  parameter logic [11:0] EVT_STEP = 12'h020,
  parameter logic [64*12-1:0] EVT_OVR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [63:0]       src_i,
  input  logic [PRI_W-1:0]  cpu_lvl_i,
  output logic              mode_o,
  output logic              irq_o,
  output logic [PRI_W-1:0]  irq_lvl_o,
  output logic [CODE_W-1:0] irq_code_o
);
  localparam int NSRC  = 64;
  localparam int PER_R = 32 / PRI_W;
  localparam int NPREG = NSRC / PER_R;
  localparam int IDX_W = $clog2(NSRC);
  localparam int PI_W  = $clog2(NPREG);

  logic [NSRC-1:0]  en_q;
  logic             mode_q;
  logic [31:0]      pri_q [NPREG];
  logic [PRI_W-1:0] pri_src [NSRC];
  logic [CODE_W-1:0] code_tab [NSRC];
  logic [NSRC-1:0]  pend;
  logic [PRI_W-1:0] best_lvl;
  logic [IDX_W-1:0] best_idx;

  wire             pri_hit = (addr_i >= ADDR_W'(8'h10)) && (addr_i <= ADDR_W'(8'h48)) && (addr_i[2:0] == 3'b0);
  wire [ADDR_W-1:0] pri_off = addr_i - ADDR_W'(8'h10);
  wire [PI_W-1:0]  pidx    = pri_off[PI_W+2:3];

  assign pend   = src_i & en_q;
  assign mode_o = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= 1'b0;
      for (int k = 0; k < NPREG; k++) pri_q[k] <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        ADDR_W'(8'h00): if (wdata_i[0]) mode_q <= 1'b1;
        ADDR_W'(8'h08): if (wdata_i[0]) mode_q <= 1'b0;
        ADDR_W'(8'h70): en_q[31:0]  <= en_q[31:0]  | wdata_i;
        ADDR_W'(8'h78): en_q[63:32] <= en_q[63:32] | wdata_i;
        ADDR_W'(8'h80): en_q[31:0]  <= en_q[31:0]  & ~wdata_i;
        ADDR_W'(8'h88): en_q[63:32] <= en_q[63:32] & ~wdata_i;
        default: if (pri_hit) pri_q[pidx] <= wdata_i;
      endcase
    end
  end

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      assign pri_src[g] = pri_q[g / PER_R][PRI_W*(g % PER_R) +: PRI_W];
      if (EVT_OVR[12*g +: 12] != 12'h0) begin : g_ovr
        assign code_tab[g] = CODE_W'(EVT_OVR[12*g +: 12]);
      end else begin : g_lin
        assign code_tab[g] = CODE_W'(EVT_BASE + EVT_STEP * 12'(g));
      end
    end
  endgenerate

  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (pend[i] && pri_src[i] > best_lvl) begin
        best_lvl = pri_src[i];
        best_idx = IDX_W'(i);
      end
  end

  assign irq_o      = best_lvl > cpu_lvl_i;
  assign irq_lvl_o  = irq_o ? best_lvl : '0;
  assign irq_code_o = irq_o ? code_tab[best_idx] : '0;

  always_comb begin
    case (addr_i)
      ADDR_W'(8'h00), ADDR_W'(8'h08): rdata_o = {31'b0, mode_q};
      ADDR_W'(8'h50): rdata_o = src_i[31:0];
      ADDR_W'(8'h58): rdata_o = src_i[63:32];
      ADDR_W'(8'h60): rdata_o = pend[31:0];
      ADDR_W'(8'h68): rdata_o = pend[63:32];
      ADDR_W'(8'h70): rdata_o = en_q[31:0];
      ADDR_W'(8'h78): rdata_o = en_q[63:32];
      default:        rdata_o = pri_hit ? pri_q[pidx] : 32'h0;
    endcase
  end

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(8'h70)) |=> ((en_q[31:0] & $past(wdata_i)) == $past(wdata_i))); // R1
  AST_DIS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(8'h80)) |=> ((en_q[31:0] & $past(wdata_i)) == 32'h0)); // R2
  AST_MODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(8'h00) && wdata_i[0]) |=> mode_o); // R3
  AST_WIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend != '0)); // R6
  AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_lvl_o > cpu_lvl_i)); // R8
endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] src = '0;
  logic [3:0]  cpu_lvl = '0;
  logic        mode;
  logic        irq;
  logic [3:0]  irq_lvl;
  logic [11:0] irq_code;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prio_intc u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .src_i(src), .cpu_lvl_i(cpu_lvl), .mode_o(mode),
    .irq_o(irq), .irq_lvl_o(irq_lvl), .irq_code_o(irq_code)
  );

  // {src, cpu level, exp irq, exp level, exp winner index}
  localparam logic [78:0] VEC [12] = '{
    {64'h0,                   4'h0, 1'b0, 4'h0, 6'd0},   // R6 idle
    {64'h2,                   4'h0, 1'b1, 4'h1, 6'd1},   // R8 lowest level
    {64'h1,                   4'h0, 1'b0, 4'h0, 6'd0},   // R6 priority 0 masks
    {64'h88,                  4'h0, 1'b1, 4'h7, 6'd7},   // R7 higher wins
    {64'h30,                  4'h0, 1'b1, 4'h4, 6'd4},   // R6 disabled src5 skipped
    {64'h200,                 4'hE, 1'b1, 4'hF, 6'd9},   // R8 above mask
    {64'h200,                 4'hF, 1'b0, 4'h0, 6'd0},   // R8 equal to mask
    {64'h8000_0004_0000_0000, 4'h0, 1'b1, 4'hA, 6'd34},  // R7 tie lowest index
    {64'h8000_0000_0000_0000, 4'h9, 1'b1, 4'hA, 6'd63},  // R8 high bank code
    {64'h0000_0004_0000_0000, 4'hA, 1'b0, 4'h0, 6'd0},   // R8 not strictly above
    {64'h140,                 4'h0, 1'b1, 4'h6, 6'd6},   // R7 src6 over src8
    {64'hFFFF_FFFF_FFFF_FFFF, 4'h0, 1'b1, 4'hF, 6'd9}    // R7 all asserted
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    rd(8'h70, d); chk("R9 en lo", 64'(d), 0);
    rd(8'h78, d); chk("R9 en hi", 64'(d), 0);
    rd(8'h28, d); chk("R9 pri", 64'(d), 0);
    rd(8'h00, d); chk("R9 mode", 64'(d), 0);
    chk("R9 mode pin", 64'(mode), 0);
    src = '1; #1 chk("R9 no irq", 64'(irq), 0);
    src = '0;

    // R1 enables with readback, zero bits keep
    wr(8'h70, 32'hFFFF_FFFF);
    wr(8'h78, 32'h8000_0004);
    wr(8'h78, 32'h0);
    rd(8'h78, d); chk("R1 hi set/keep", 64'(d), 64'h8000_0004);
    // R2 disable src5, zero bits keep
    wr(8'h80, 32'h20);
    wr(8'h80, 32'h0);
    rd(8'h70, d); chk("R2 lo clear", 64'(d), 64'hFFFF_FFDF);

    // R4 priorities
    wr(8'h10, 32'h7654_3210);
    wr(8'h18, 32'h0000_00F1);
    wr(8'h30, 32'h0000_0A00);
    wr(8'h48, 32'hA000_0000);
    rd(8'h18, d); chk("R4 reg1", 64'(d), 64'hF1);
    rd(8'h48, d); chk("R4 reg7", 64'(d), 64'hA000_0000);

    // R5 raw and pending status
    @(negedge clk); src = 64'h8000_0001_0000_0030;
    rd(8'h50, d); chk("R5 raw lo", 64'(d), 64'h30);
    rd(8'h58, d); chk("R5 raw hi", 64'(d), 64'h8000_0001);
    rd(8'h60, d); chk("R5 pend lo", 64'(d), 64'h10);
    rd(8'h68, d); chk("R5 pend hi", 64'(d), 64'h8000_0000);

    // R6 R7 R8 vector table
    for (int v = 0; v < 12; v++) begin
      @(negedge clk);
      src = VEC[v][78:15]; cpu_lvl = VEC[v][14:11];
      #1;
      chk($sformatf("R8 irq v%0d", v), 64'(irq), 64'(VEC[v][10]));
      chk($sformatf("R7 lvl v%0d", v), 64'(irq_lvl), 64'(VEC[v][9:6]));
      chk($sformatf("R8 code v%0d", v), 64'(irq_code),
          VEC[v][10] ? 64'(12'h200 + 12'h20 * 12'(VEC[v][5:0])) : 64'h0);
    end

    // R6 level sensitive: drop input, request drops
    @(negedge clk); src = 64'h200; cpu_lvl = 4'h0;
    #1 chk("R6 held", 64'(irq), 1);
    @(negedge clk); src = 64'h0;
    #1 chk("R6 dropped", 64'(irq), 0);

    // R3 control bit
    wr(8'h00, 32'h1);
    rd(8'h08, d); chk("R3 set", 64'(d), 1);
    wr(8'h08, 32'hFFFF_FFFE);
    chk("R3 clear bit0=0 keeps", 64'(mode), 1);
    wr(8'h08, 32'h1);
    rd(8'h00, d); chk("R3 cleared", 64'(d), 0);

    // R2 disabling the winner removes its request
    @(negedge clk); src = 64'h8000_0000_0000_0000; cpu_lvl = 4'h0;
    wr(8'h88, 32'h8000_0000);
    #1 chk("R2 disabled src63", 64'(irq), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule